// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog whose timeout is split into two back-to-back phases. A closed phase comes first: software must not refresh the timer during it. An open phase follows, and software must refresh the timer before it runs out. Both phase lengths are counted in clock cycles and held in 32-bit registers. Software writes them while the timer is stopped, then sets the enable bit to start the closed phase.

The control/status register is write-protected. Each write to it must follow an unlock written to a separate write-control register, and the unlock is used up by that one accepted write. Software refreshes the timer with a protected write that keeps the enable bit set and sets the restart bit. A refresh in the open phase restarts the closed phase. A refresh in the closed phase is a fault, and so is an open phase that runs out. Either fault raises a flag that software can clear, and a reset-request output that stays high until the block is reset.

The register offsets are fixed because driver software decodes them: 0x00 write-control, 0x04 control/status, 0x08 function control (reserved here), 0x0C closed-phase length, 0x10 open-phase length.

Top module: `win_watchdog`

## Requirements
- R1: Writing 1 to bit 0 at offset 0x00 arms the write unlock, which reads back on bit 0 of 0x00. The first accepted write to 0x04 clears it again.
- R2: A write to 0x04 while the unlock is not armed changes nothing: enable, flag and timer all keep their state.
- R3: Offset 0x04 reads back enable on bit 0, the fault flag on bit 16, and zero on every other bit, including the restart bit 8. Offset 0x08 and unmapped offsets read zero.
- R4: Offset 0x0C holds the closed length C and 0x10 holds the open length O. Both can be written without an unlock while the timer is disabled, and writes to them are ignored while it is enabled.
- R5: Counting from the clock edge that sets enable from 0 to 1, a restart at the k-th later edge falls in the closed phase for 1 ≤ k ≤ C+1 and in the open phase for C+2 ≤ k ≤ C+O+2.
- R6: A restart (a protected write with bits 0 and 8 set while enabled) in the closed phase raises the flag and reset_req at that same edge.
- R7: A restart in the open phase does not fault, and timing restarts as if the timer had been enabled at that edge.
- R8: With no restart, the flag and reset_req rise at edge C+O+2 after enabling, and not at edge C+O+1.
- R9: Writing 1 to bit 16 in a protected write clears the flag. reset_req stays high until reset.
- R10: After reset all registers read zero, and irq and reset_req are low.
- R11: Clearing enable stops the timer, so no fault occurs while it is disabled. Enabling again starts a fresh closed phase of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timebase for the window counts |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Fault flag (bit 16 of 0x04) |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with its default parameters: a 5-bit offset and 32-bit counters. The window lengths are registers, not parameters, so the bench programs short windows (C=5, O=4). This brings every phase boundary within a few cycles: the last closed edge, the first and last open edges, the timeout edge, and the reload after a restart. The closed and open windows differ in length, so an exchanged or off-by-one boundary shows up at a distinct edge.

// File: rtl/ww_pkg.sv
// Shared definitions for the windowed watchdog: phase encoding,
// register offsets and control/status bit positions.
package ww_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CLOSED  = 2'd1,
        PH_OPEN    = 2'd2,
        PH_EXPIRED = 2'd3
    } ww_phase_e;

    localparam int OFS_UNLOCK = 'h00;
    localparam int OFS_CTRL   = 'h04;
    localparam int OFS_FUNC   = 'h08;
    localparam int OFS_CLOSED = 'h0C;
    localparam int OFS_OPEN   = 'h10;

    localparam int BIT_EN    = 0;
    localparam int BIT_KICK  = 8;
    localparam int BIT_FLAG  = 16;
    localparam int DATA_W    = 32;
endpackage

// File: rtl/ww_regs.sv
// Register file of the windowed watchdog.
// Decodes writes, gates the control/status register behind a one-shot
// unlock, holds enable and the window lengths, and produces start,
// restart and flag-clear pulses for the timer.
// Assumes CNT_W <= 32 and a single-cycle write strobe.
module ww_regs
    import ww_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              unlock,
    output logic              tmr_en,
    output logic [CNT_W-1:0]  closed_len,
    output logic [CNT_W-1:0]  open_len,
    output logic              start,
    output logic              kick,
    output logic              flag_clr
);
    logic wr, hit_unlock, hit_ctrl, hit_closed, hit_open, ctrl_acc;

    // Address decode and protected-write qualification.
    always_comb begin
        wr         = bus_valid && bus_write;
        hit_unlock = (bus_addr == ADDR_W'(OFS_UNLOCK));
        hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_closed = (bus_addr == ADDR_W'(OFS_CLOSED));
        hit_open   = (bus_addr == ADDR_W'(OFS_OPEN));
        ctrl_acc   = wr && hit_ctrl && unlock;
        start      = ctrl_acc && bus_wdata[BIT_EN] && !tmr_en;
        kick       = ctrl_acc && bus_wdata[BIT_EN] && bus_wdata[BIT_KICK] && tmr_en;
        flag_clr   = ctrl_acc && bus_wdata[BIT_FLAG];
    end

    // One-shot unlock: armed by write-control, consumed by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlock <= 1'b0;
        else if (ctrl_acc)
            unlock <= 1'b0;
        else if (wr && hit_unlock)
            unlock <= bus_wdata[0];
    end

    // Enable bit, written only through an accepted protected write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_en <= 1'b0;
        else if (ctrl_acc)
            tmr_en <= bus_wdata[BIT_EN];
    end

    // Window lengths, writable only while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed_len <= '0;
            open_len   <= '0;
        end else if (wr && !tmr_en) begin
            if (hit_closed) closed_len <= bus_wdata[CNT_W-1:0];
            if (hit_open)   open_len   <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer; the restart bit and reserved fields read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_unlock) begin
            bus_rdata[0] = unlock;
        end else if (hit_ctrl) begin
            bus_rdata[BIT_EN]   = tmr_en;
            bus_rdata[BIT_FLAG] = flag;
        end else if (hit_closed) begin
            bus_rdata = DATA_W'(closed_len);
        end else if (hit_open) begin
            bus_rdata = DATA_W'(open_len);
        end
    end
endmodule

// File: rtl/ww_timer.sv
// Two-phase down-counter of the windowed watchdog.
// Runs the closed phase then the open phase, judges restarts against
// the current phase, and raises the fault flag and sticky reset request.
// Assumes start and kick never coincide (kick needs enable already set).
module ww_timer
    import ww_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             start,
    input  logic             kick,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] closed_len,
    input  logic [CNT_W-1:0] open_len,
    output ww_phase_e        phase,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             rst_req
);
    logic cnt_zero, violation, expire, fault;

    // Fault detection for the current cycle.
    always_comb begin
        cnt_zero  = (cnt == '0);
        violation = kick && (phase == PH_CLOSED);
        expire    = tmr_en && (phase == PH_OPEN) && cnt_zero && !kick;
        fault     = violation || expire;
    end

    // Phase sequencing and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_CLOSED;
            cnt   <= closed_len;
        end else if (!tmr_en) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_CLOSED: begin
                    if (violation) begin
                        phase <= PH_EXPIRED;
                    end else if (cnt_zero) begin
                        phase <= PH_OPEN;
                        cnt   <= open_len;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_OPEN: begin
                    if (kick) begin
                        phase <= PH_CLOSED;
                        cnt   <= closed_len;
                    end else if (cnt_zero) begin
                        phase <= PH_EXPIRED;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= phase;
            endcase
        end
    end

    // Fault flag (software-clearable) and sticky reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            flag    <= fault ? 1'b1 : (flag_clr ? 1'b0 : flag);
            rst_req <= rst_req || fault;
        end
    end
endmodule

// File: rtl/win_watchdog.sv
// Top of the windowed watchdog: register file plus two-phase timer.
// Assumes a simple single-cycle register bus with combinational reads.
module win_watchdog
    import ww_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              reset_req
);
    logic             unlock, tmr_en, start, kick, flag_clr, flag;
    logic [CNT_W-1:0] closed_len, open_len, cnt;
    ww_phase_e        phase;

    ww_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .flag       (flag),
        .bus_rdata  (bus_rdata),
        .unlock     (unlock),
        .tmr_en     (tmr_en),
        .closed_len (closed_len),
        .open_len   (open_len),
        .start      (start),
        .kick       (kick),
        .flag_clr   (flag_clr)
    );

    ww_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_en     (tmr_en),
        .start      (start),
        .kick       (kick),
        .flag_clr   (flag_clr),
        .closed_len (closed_len),
        .open_len   (open_len),
        .phase      (phase),
        .cnt        (cnt),
        .flag       (flag),
        .rst_req    (reset_req)
    );

    assign irq = flag;
endmodule

// File: rtl/ww_checker.sv
// Property checker for the windowed watchdog, bound into the top module.
module ww_checker
    import ww_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              reset_req,
    input logic              unlock,
    input logic              tmr_en,
    input logic              kick,
    input logic              start,
    input ww_phase_e         phase,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  closed_len
);
    logic ctrl_wr;
    assign ctrl_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CTRL));

    assert_unlock_consumed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && unlock |=> !unlock);

    assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !unlock |=> $stable(tmr_en));

    assert_kick_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CTRL)) |-> !bus_rdata[BIT_KICK]);

    assert_window_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_en && bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CLOSED))
        |=> $stable(closed_len));

    assert_early_kick_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick && (phase == PH_CLOSED) |=> irq && reset_req);

    assert_timeout_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_en && !start && !kick && (phase == PH_OPEN) && (cnt == '0)
        |=> irq && reset_req);

    assert_reset_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);
endmodule

bind win_watchdog ww_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .reset_req  (reset_req),
    .unlock     (unlock),
    .tmr_en     (tmr_en),
    .kick       (kick),
    .start      (start),
    .phase      (phase),
    .cnt        (cnt),
    .closed_len (closed_len)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
    localparam int PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int CL     = 5;   // closed length programmed by the bench
    localparam int OL     = 4;   // open length programmed by the bench

    typedef struct packed {
        logic        pre_unlock;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b0, 5'h0C, 32'd5,        5'h0C, 32'd5,        4'd4},  // R4 closed length
        '{1'b0, 5'h10, 32'd4,        5'h10, 32'd4,        4'd4},  // R4 open length
        '{1'b0, 5'h04, 32'h1,        5'h04, 32'h0,        4'd2},  // R2 locked write
        '{1'b0, 5'h00, 32'h1,        5'h00, 32'h1,        4'd1},  // R1 unlock readback
        '{1'b0, 5'h04, 32'h100,      5'h04, 32'h0,        4'd3},  // R3 restart reads 0
        '{1'b0, 5'h08, 32'hFFFFFFFF, 5'h00, 32'h0,        4'd1},  // R1 unlock consumed
        '{1'b0, 5'h14, 32'hFFFFFFFF, 5'h08, 32'h0,        4'd3},  // R3 reserved zero
        '{1'b1, 5'h04, 32'h1,        5'h04, 32'h1,        4'd3},  // R3 enable bit
        '{1'b0, 5'h0C, 32'd99,       5'h0C, 32'd5,        4'd4},  // R4 frozen
        '{1'b1, 5'h04, 32'h0,        5'h04, 32'h0,        4'd11}, // R11 disable
        '{1'b0, 5'h0C, 32'd5,        5'h0C, 32'd5,        4'd4}   // R4 writable again
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq, reset_req;
    int                n_chk = 0;
    int                n_fail = 0;

    win_watchdog #(.ADDR_W(ADDR_W)) u_win_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .reset_req(reset_req)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic setup_enable();
        wr(5'h0C, CL);
        wr(5'h10, OL);
        wr(5'h00, 32'h1);
        wr(5'h04, 32'h1);   // enabling edge
    endtask

    task automatic kick_locked();
        wr(5'h00, 32'h1);
        wr(5'h04, 32'h101);
    endtask

    logic [31:0] rv;

    initial begin
        // R10 reset state
        do_reset();
        rd(5'h00, rv); check("R10 write-control", rv, 0);
        rd(5'h04, rv); check("R10 status", rv, 0);
        rd(5'h0C, rv); check("R10 closed", rv, 0);
        rd(5'h10, rv); check("R10 open", rv, 0);
        check("R10 irq", {31'b0, irq}, 0);
        check("R10 reset_req", {31'b0, reset_req}, 0);

        // Register vector table
        for (int i = 0; i < 11; i++) begin
            if (VEC[i].pre_unlock) wr(5'h00, 32'h1);
            wr(VEC[i].waddr, VEC[i].wdata);
            rd(VEC[i].raddr, rv);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].exp);
        end

        // R5/R6: restart at edge C+1 is still closed
        do_reset(); setup_enable(); idle(CL - 1); kick_locked();
        check("R6 early restart irq", {31'b0, irq}, 1);
        check("R6 early restart reset_req", {31'b0, reset_req}, 1);

        // R5/R7: restart at edge C+2 is open, then timing reloads
        do_reset(); setup_enable(); idle(CL); kick_locked();
        check("R5 first open restart", {31'b0, irq}, 0);
        idle(CL + OL + 1);
        check("R7 no fault before reload timeout", {31'b0, irq}, 0);
        idle(1);
        check("R7 timeout after reload", {31'b0, reset_req}, 1);

        // R5: restart at last open edge C+O+2 is honoured
        do_reset(); setup_enable(); idle(CL + OL); kick_locked();
        check("R5 last open restart", {31'b0, reset_req}, 0);

        // R8 timeout boundary, R3 flag readback, R9 clear and stickiness
        do_reset(); setup_enable(); idle(CL + OL + 1);
        check("R8 no fault at C+O+1", {31'b0, irq}, 0);
        idle(1);
        check("R8 irq at C+O+2", {31'b0, irq}, 1);
        check("R8 reset_req at C+O+2", {31'b0, reset_req}, 1);
        rd(5'h04, rv); check("R3 status with flag", rv, 32'h10001);
        wr(5'h00, 32'h1); wr(5'h04, 32'h10001);
        check("R9 flag cleared", {31'b0, irq}, 0);
        idle(20);
        check("R9 reset_req sticky", {31'b0, reset_req}, 1);

        // R11 disable stops timer; re-enable starts a full closed phase
        do_reset(); setup_enable(); idle(3);
        wr(5'h00, 32'h1); wr(5'h04, 32'h0);
        idle(30);
        check("R11 no fault while disabled", {31'b0, reset_req}, 0);
        wr(5'h00, 32'h1); wr(5'h04, 32'h1);
        idle(CL - 1); kick_locked();
        check("R11 fresh closed phase", {31'b0, irq}, 1);

        // R2 restart without unlock has no effect
        do_reset(); setup_enable(); idle(1);
        wr(5'h04, 32'h101);
        check("R2 locked restart ignored", {31'b0, irq}, 0);
        rd(5'h04, rv); check("R2 status unchanged", rv, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule